// File: doc/BRIEF.md
# Compare Match Timer Channel

This block is one timer channel. A 16-bit up-counter advances once per pulse from a prescaler, which divides the system clock by a power of two picked by a two-bit select field. When the counter has reached the value held in the compare register, the next count pulse sets a sticky match flag and returns the counter to zero. The flag drives a level interrupt output when the interrupt enable is set.

Software reaches the channel through a plain register port: a select, write and read strobe, a two-bit word address, and 16-bit write and read data. Read data always reflects the addressed word. A read strobe has one side effect: it arms the flag for clearing. The flag then clears only when a zero is written to it after it has been read as one. Two standby inputs are provided. Software standby wipes the control/status word. Module standby freezes the whole channel in its current state.

All pins are plain control and status signals. There is no streaming interface, so there is no valid/ready handshake and no back-pressure.

Top module: `cmt_channel`

## Requirements
- R1: After reset the control/status word reads 0x0000, the counter reads 0, the compare register reads 0xFFFF, the run word reads 0 and irq is low.
- R2: Word address 0 is the control/status word: bit 7 is the match flag, bit 6 the interrupt enable, and bits 1:0 the clock select. Bits 15:8 and 5:2 always read 0, and writes to them are ignored. Address 1 is the counter, address 2 the compare value, and address 3 the run word, which uses only bit 0.
- R3: Clock select codes 0, 1, 2 and 3 give one count every 8, 32, 128 and 512 clocks. The prescaler is held at 0 while the run bit is 0. After run is written to 1, the counter has advanced floor(E/div) times E clock edges later.
- R4: On a count pulse with counter equal to compare, the counter returns to 0 and the flag is set. With a compare value of 0, the counter stays at 0 and the first count pulse sets the flag.
- R5: Writing 1 to the flag bit does not set it. Writing 0 clears it only if the control/status word was read with the flag at 1 since the last write to that word. Otherwise the flag stays set.
- R6: Every write to the control/status word removes the armed state, so a write that leaves bit 7 at 1 consumes the arming.
- R7: When a match and a clearing write land on the same edge, the flag ends up set.
- R8: irq is high exactly while both the flag and the interrupt enable are 1.
- R9: While sw_standby is high, the control/status word and the armed state are held at 0, and writes to that word are ignored.
- R10: While mod_standby is high, the counter, prescaler, compare, run and control/status state all hold their values and every register write is ignored. Counting resumes from the frozen prescaler phase after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sw_standby | input | 1 | Software standby: clears the control/status word |
| mod_standby | input | 1 | Module standby: freezes the channel |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag for clearing) |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word |
| irq | output | 1 | Compare match interrupt, level |

## Verification
The checker watches several rules on every cycle:
- reserved control/status bits stay at zero;
- a match always leaves the flag set, even against a clearing write;
- the flag never rises without a match;
- the flag never falls except through an armed zero-write or software standby;
- the counter moves only on a count pulse or a write;
- nothing moves under module standby;
- irq tracks the flag and enable.

The divide ratios, the wrap period for each compare value, the read-then-write clearing order and resumption after module standby all depend on exact cycle counts. Only the bench's timed scenarios can show those.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int ADDR_W   = 2;
  localparam int WORD_W   = 16;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CSR   = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_MATCH = 2'd2,
    ADDR_RUN   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int SEL_W    = 2,
  parameter int DIV_BASE = 3,
  parameter int DIV_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int PSC_W = DIV_BASE + DIV_STEP * (NSEL - 1);

  logic [PSC_W-1:0] psc_q;
  logic [NSEL-1:0]  tap;

  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    localparam int BITS = DIV_BASE + DIV_STEP * g;
    assign tap[g] = &psc_q[BITS-1:0];
  end

  assign tick = tap[sel] & run & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     psc_q <= '0;
    else if (!run)  psc_q <= '0;
    else if (!hold) psc_q <= psc_q + 1'b1;
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] compare,
  output logic             match_evt
);
  assign match_evt = tick & (count == compare);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      compare <= '1;
    end else if (!hold) begin
      if (cnt_wr)         count <= wdata;
      else if (match_evt) count <= '0;
      else if (tick)      count <= count + 1'b1;
      if (cmp_wr)         compare <= wdata;
    end
  end
endmodule

// File: rtl/cmt_ctrl_status.sv
module cmt_ctrl_status
  import cmt_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_standby,
  input  logic              hold,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              match_evt,
  output logic              flag,
  output logic              ie,
  output logic              armed,
  output logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] csr_word
);
  logic clear_ok;
  assign clear_ok = armed & ~wdata[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      ie    <= 1'b0;
      armed <= 1'b0;
      sel   <= '0;
    end else if (sw_standby) begin
      flag  <= 1'b0;
      ie    <= 1'b0;
      armed <= 1'b0;
      sel   <= '0;
    end else if (!hold) begin
      if (wr_en) begin
        ie    <= wdata[IE_BIT];
        sel   <= wdata[SEL_W-1:0];
        armed <= 1'b0;
        flag  <= match_evt | (flag & ~clear_ok);
      end else begin
        flag <= flag | match_evt;
        if (rd_en && flag) armed <= 1'b1;
      end
    end
  end

  always_comb begin
    csr_word              = '0;
    csr_word[FLAG_BIT]    = flag;
    csr_word[IE_BIT]      = ie;
    csr_word[SEL_W-1:0]   = sel;
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 2,
  parameter int DIV_BASE = 3,
  parameter int DIV_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_standby,
  input  logic              mod_standby,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  logic              wr_any, wr_csr, wr_count, wr_match, wr_run, rd_csr;
  logic              run_q, tick, match_evt;
  logic              flag, ie, armed;
  logic [SEL_W-1:0]  sel;
  logic [CNT_W-1:0]  count, compare;
  logic [WORD_W-1:0] csr_word;

  assign wr_any   = bus_sel & bus_wr & ~mod_standby;
  assign wr_csr   = wr_any & (bus_addr == ADDR_CSR);
  assign wr_count = wr_any & (bus_addr == ADDR_COUNT);
  assign wr_match = wr_any & (bus_addr == ADDR_MATCH);
  assign wr_run   = wr_any & (bus_addr == ADDR_RUN);
  assign rd_csr   = bus_sel & bus_rd & (bus_addr == ADDR_CSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (wr_run) run_q <= bus_wdata[0];
  end

  cmt_prescaler #(
    .SEL_W(SEL_W), .DIV_BASE(DIV_BASE), .DIV_STEP(DIV_STEP)
  ) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .hold(mod_standby),
    .sel(sel), .tick(tick)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold(mod_standby), .tick(tick),
    .cnt_wr(wr_count), .cmp_wr(wr_match), .wdata(bus_wdata[CNT_W-1:0]),
    .count(count), .compare(compare), .match_evt(match_evt)
  );

  cmt_ctrl_status #(.SEL_W(SEL_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .sw_standby(sw_standby), .hold(mod_standby),
    .wr_en(wr_csr), .rd_en(rd_csr), .wdata(bus_wdata),
    .match_evt(match_evt), .flag(flag), .ie(ie), .armed(armed),
    .sel(sel), .csr_word(csr_word)
  );

  assign irq = flag & ie;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CSR:   bus_rdata = csr_word;
      ADDR_COUNT: bus_rdata[CNT_W-1:0] = count;
      ADDR_MATCH: bus_rdata[CNT_W-1:0] = compare;
      default:    bus_rdata[0] = run_q;
    endcase
  end
endmodule

// File: rtl/cmt_channel_sva.sv
module cmt_channel_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_standby,
  input logic        mod_standby,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        irq,
  input logic        flag,
  input logic        ie,
  input logic        armed,
  input logic        tick,
  input logic        match_evt,
  input logic        wr_csr,
  input logic        wr_count,
  input logic [15:0] count
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[15:8] == 8'h00 && bus_rdata[5:2] == 4'h0));

  assert_count_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_count) |=> $stable(count));

  assert_match_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !sw_standby) |=> flag);

  assert_flag_rise_needs_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(match_evt));

  assert_flag_fall_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(sw_standby) ||
                     ($past(armed) && $past(wr_csr) && !$past(bus_wdata[7]))));

  assert_write_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_csr |=> !armed);

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && wr_csr && !sw_standby) |=> flag);

  assert_irq_needs_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie));

  assert_swstby_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_standby |=> (!flag && !ie && !armed));

  assert_modstby_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_standby && !sw_standby) |=> ($stable(count) && $stable(flag) && $stable(ie)));
endmodule

bind cmt_channel cmt_channel_sva u_sva (
  .clk(clk), .rst_n(rst_n), .sw_standby(sw_standby), .mod_standby(mod_standby),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .flag(flag), .ie(ie), .armed(armed), .tick(tick), .match_evt(match_evt),
  .wr_csr(wr_csr), .wr_count(wr_count), .count(count)
);

// File: tb/cmt_channel_tb.sv
module cmt_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_standby = 1'b0;
  logic        mod_standby = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmt_channel u_dut (
    .clk(clk), .rst_n(rst_n), .sw_standby(sw_standby), .mod_standby(mod_standby),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        ie;
    logic [15:0] cmp;
    logic [15:0] wait_cyc;
    logic [15:0] exp_cnt;
    logic        exp_flag;
    logic        exp_irq;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 16'd5,  16'd24,  16'd3, 1'b0, 1'b0},
    '{2'd0, 1'b1, 16'd2,  16'd24,  16'd0, 1'b1, 1'b1},
    '{2'd1, 1'b1, 16'd3,  16'd100, 16'd3, 1'b0, 1'b0},
    '{2'd2, 1'b0, 16'd1,  16'd300, 16'd0, 1'b1, 1'b0},
    '{2'd3, 1'b1, 16'd0,  16'd500, 16'd0, 1'b0, 1'b0},
    '{2'd3, 1'b1, 16'd0,  16'd600, 16'd0, 1'b1, 1'b1},
    '{2'd0, 1'b0, 16'd10, 16'd47,  16'd5, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; consumes exactly one rising edge.
  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 16'h0;
  endtask

  task automatic rd_csr();
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 2'd0;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);
    do_reset();

    // R1 reset state
    peek(2'd0, v); chk("R1 csr", v, 16'h0000);
    peek(2'd1, v); chk("R1 count", v, 16'h0000);
    peek(2'd2, v); chk("R1 compare", v, 16'hFFFF);
    peek(2'd3, v); chk("R1 run", v, 16'h0000);
    chk("R1 irq", irq, 1'b0);

    // R2 reserved bits, R5 write of 1 does not set flag
    wr_reg(2'd0, 16'hFFFF);
    peek(2'd0, v); chk("R2 reserved bits read 0", v, 16'h0043);
    chk("R5 write one leaves flag clear", v[7], 1'b0);

    // R3/R4/R8 vector table
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      wr_reg(2'd2, VECS[i].cmp);
      wr_reg(2'd0, {9'd0, VECS[i].ie, 4'd0, VECS[i].sel});
      wr_reg(2'd3, 16'h0001);
      repeat (int'(VECS[i].wait_cyc)) @(negedge clk);
      peek(2'd1, v); chk($sformatf("R3/R4 count vec%0d", i), v, VECS[i].exp_cnt);
      peek(2'd0, v); chk($sformatf("R4 flag vec%0d", i), v[7], VECS[i].exp_flag);
      chk($sformatf("R8 irq vec%0d", i), irq, VECS[i].exp_irq);
    end

    // R7 clearing write on the same edge as a match (compare 0, divide 8)
    do_reset();
    wr_reg(2'd2, 16'd0);
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd3, 16'h0001);
    repeat (14) @(negedge clk);
    rd_csr();
    wr_reg(2'd0, 16'h0000);
    peek(2'd0, v); chk("R7 set wins over clear", v[7], 1'b1);
    wr_reg(2'd3, 16'h0000);

    // R5 write zero without read keeps flag
    wr_reg(2'd0, 16'h0000);
    peek(2'd0, v); chk("R5 unarmed clear ignored", v[7], 1'b1);
    // R6 write of 1 consumes arming
    rd_csr();
    wr_reg(2'd0, 16'h0080);
    wr_reg(2'd0, 16'h0000);
    peek(2'd0, v); chk("R6 disarmed by write", v[7], 1'b1);
    // R5 proper handshake clears
    rd_csr();
    wr_reg(2'd0, 16'h0000);
    peek(2'd0, v); chk("R5 armed clear", v[7], 1'b0);

    // R10 module standby freezes and ignores writes
    do_reset();
    wr_reg(2'd2, 16'd100);
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd3, 16'h0001);
    repeat (20) @(negedge clk);
    mod_standby = 1'b1;
    repeat (40) @(negedge clk);
    wr_reg(2'd0, 16'h0042);
    wr_reg(2'd2, 16'd7);
    peek(2'd1, v); chk("R10 count frozen", v, 16'd2);
    peek(2'd0, v); chk("R10 csr write ignored", v, 16'h0000);
    peek(2'd2, v); chk("R10 compare write ignored", v, 16'd100);
    mod_standby = 1'b0;
    repeat (8) @(negedge clk);
    peek(2'd1, v); chk("R10 resumes from frozen phase", v, 16'd3);

    // R9 software standby
    do_reset();
    wr_reg(2'd0, 16'h0041);
    peek(2'd0, v); chk("R9 pre-standby csr", v, 16'h0041);
    sw_standby = 1'b1;
    wr_reg(2'd0, 16'h0042);
    peek(2'd0, v); chk("R9 csr cleared and write ignored", v, 16'h0000);
    sw_standby = 1'b0;
    @(negedge clk);
    peek(2'd0, v); chk("R9 csr stays clear", v, 16'h0000);
    chk("R9 irq low", irq, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule